// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the core of an eight-input interrupt controller. It samples raw request lines into a pending-request register. Each line is edge- or level-sensitive, chosen by its own bit. The block removes masked lines and finds the most urgent pending line. It raises an interrupt output when that line outranks every line already being serviced.

Priority is circular. The scan starts at a stored rotation offset, and the offset moves past the serviced line when rotation on automatic end-of-interrupt is enabled. An acknowledge strobe moves the winning line into service. A separate clear strobe with a line index ends service for that line. When the block is the master and special nesting is on, the cascade input (line 2) is left out of the in-service ranking. This lets a second controller behind that input nest its own requests.

Top module: `prio_irq_resolver`

## Requirements
- R1: While reset is asserted, the pending, remembered-level, in-service and mask registers are zero, the rotation offset is 0, and irqOut and wakePulse are low.
- R2: For an edge-sensitive line (levelMode bit 0), a request is latched only when the line is sampled high after being sampled low. A line that stays high after acknowledge does not request again. Dropping the line does not withdraw a latched request.
- R3: For a level-sensitive line (levelMode bit 1), the pending bit follows the sampled input: high sets it and low clears it. Acknowledge does not clear it.
- R4: A line whose maskBits bit is 1 never wins. Its latched request stays pending and wins once the mask bit is cleared.
- R5: Priority is scanned at positions p = 0 to 7 over line (p + offset) mod 8. A lower p is more urgent, and the reported line is (p + offset) mod 8. After reset the offset is 0, so line 0 is most urgent and line 7 least.
- R6: A pending line is presented only if its priority is strictly better than the best in-service priority. A line of equal or worse priority waits.
- R7: Acknowledge with a valid winner and autoEoi low sets that line's in-service bit. It clears the winner's pending bit if the line is edge-sensitive.
- R8: eoiStrobe clears the in-service bit of line eoiLine.
- R9: With isMaster and fullyNested both 1, in-service bit 2 is ignored in the ranking. With isMaster 0, it counts as usual.
- R10: With autoEoi 1, acknowledge leaves no in-service bit set. If rotateOnAutoEoi is also 1, the offset becomes (acknowledged line + 1) mod 8.
- R11: irqOut and irqLine are registered and show the state one clock later. wakePulse is high for exactly the cycle in which irqOut rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqLines | input | 8 | Raw request lines |
| maskBits | input | 8 | Per-line mask, 1 = blocked |
| levelMode | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| isMaster | input | 1 | Role strap, 1 = master |
| fullyNested | input | 1 | Special fully nested mode enable |
| autoEoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rotateOnAutoEoi | input | 1 | Rotate priority on automatic end-of-interrupt |
| ackStrobe | input | 1 | Acknowledge of the current winner |
| eoiStrobe | input | 1 | Clear one in-service bit |
| eoiLine | input | 3 | Line whose in-service bit is cleared |
| irqOut | output | 1 | Registered interrupt request |
| irqLine | output | 3 | Registered winning line number |
| wakePulse | output | 1 | One-cycle pulse on irqOut rising |

## Verification
The bench holds an edge line high across its acknowledge. A resolver that re-latched on level would then raise a second interrupt. It raises a line equal to one in service, which exposes a non-strict comparison. It also holds a level line through acknowledge and end-of-interrupt, so a design that cleared the level request on acknowledge would go silent. Rotation is shown with lines 0 and 7 both pending: after one automatic end-of-interrupt, line 7 must win, not line 0. Line 2 in service is checked in master and slave roles, so a design that ignored the role strap gives the wrong answer in one of the two.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic setIsr;      // mark winner in service
    logic clrReq;      // drop winner's edge request
    logic loadOffset;  // rotate: offset <= winner + 1
    logic clrIsr;      // end service of eoiLine
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_res_datapath.sv
module irq_res_datapath
  import irq_res_pkg::*;
#(
  parameter int N = 8,
  parameter int CASC = 2,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  reqLines,
  input  logic [N-1:0]  maskBits,
  input  logic [N-1:0]  levelMode,
  input  logic          isMaster,
  input  logic          fullyNested,
  input  logic [IW-1:0] eoiLine,
  input  ctrlStrobe_t   strobe,
  output logic          candValid,
  output logic [IW-1:0] candLine,
  output logic [N-1:0]  reqQ,
  output logic [N-1:0]  isrQ,
  output logic [N-1:0]  maskQ,
  output logic [IW-1:0] offsetQ
);
  logic [N-1:0] prevQ;
  logic [N-1:0] isrRanked;
  logic [IW:0]  reqPrio;
  logic [IW:0]  isrPrio;
  logic [N-1:0] cascBit;

  // Position of the first set bit scanning upward from the offset; N if none
  function automatic logic [IW:0] scanPrio(input logic [N-1:0] bits, input logic [IW-1:0] off);
    logic [IW:0] res;
    logic [IW-1:0] idx;
    res = (IW+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      idx = off + IW'(p);
      if (bits[idx]) res = (IW+1)'(p);
    end
    return res;
  endfunction

  assign cascBit   = N'(1) << CASC;
  assign isrRanked = (isMaster && fullyNested) ? (isrQ & ~cascBit) : isrQ;
  assign reqPrio   = scanPrio(reqQ & ~maskQ, offsetQ);
  assign isrPrio   = scanPrio(isrRanked, offsetQ);
  assign candValid = reqPrio < isrPrio;
  assign candLine  = offsetQ + reqPrio[IW-1:0];

  // Per-line request capture
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ[i]  <= 1'b0;
        prevQ[i] <= 1'b0;
      end else begin
        prevQ[i] <= reqLines[i];
        if (levelMode[i]) begin
          reqQ[i] <= reqLines[i];
        end else if (reqLines[i] && !prevQ[i]) begin
          reqQ[i] <= 1'b1;
        end else if (strobe.clrReq && candLine == IW'(i)) begin
          reqQ[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrQ    <= '0;
      maskQ   <= '0;
      offsetQ <= '0;
    end else begin
      maskQ <= maskBits;
      if (strobe.clrIsr) isrQ[eoiLine] <= 1'b0;
      if (strobe.setIsr) isrQ[candLine] <= 1'b1;
      if (strobe.loadOffset) offsetQ <= candLine + IW'(1);
    end
  end
endmodule

// File: rtl/irq_res_control.sv
module irq_res_control
  import irq_res_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ackStrobe,
  input  logic          eoiStrobe,
  input  logic          autoEoi,
  input  logic          rotateOnAutoEoi,
  input  logic          candValid,
  input  logic [IW-1:0] candLine,
  output ctrlStrobe_t   strobe,
  output logic          irqOut,
  output logic [IW-1:0] irqLine,
  output logic          wakePulse
);
  logic ackTaken;

  assign ackTaken          = ackStrobe && candValid;
  assign strobe.setIsr     = ackTaken && !autoEoi;
  assign strobe.clrReq     = ackTaken;
  assign strobe.loadOffset = ackTaken && autoEoi && rotateOnAutoEoi;
  assign strobe.clrIsr     = eoiStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut    <= 1'b0;
      irqLine   <= '0;
      wakePulse <= 1'b0;
    end else begin
      irqOut    <= candValid;
      irqLine   <= candValid ? candLine : '0;
      wakePulse <= candValid && !irqOut;
    end
  end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import irq_res_pkg::*;
#(
  parameter int N = 8,
  parameter int CASC = 2,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  reqLines,
  input  logic [N-1:0]  maskBits,
  input  logic [N-1:0]  levelMode,
  input  logic          isMaster,
  input  logic          fullyNested,
  input  logic          autoEoi,
  input  logic          rotateOnAutoEoi,
  input  logic          ackStrobe,
  input  logic          eoiStrobe,
  input  logic [IW-1:0] eoiLine,
  output logic          irqOut,
  output logic [IW-1:0] irqLine,
  output logic          wakePulse
);
  ctrlStrobe_t   strobe;
  logic          candValid;
  logic [IW-1:0] candLine;
  logic [N-1:0]  reqQ;
  logic [N-1:0]  isrQ;
  logic [N-1:0]  maskQ;
  logic [IW-1:0] offsetQ;

  irq_res_datapath #(.N(N), .CASC(CASC)) u_dp (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .maskBits(maskBits),
    .levelMode(levelMode), .isMaster(isMaster), .fullyNested(fullyNested),
    .eoiLine(eoiLine), .strobe(strobe), .candValid(candValid),
    .candLine(candLine), .reqQ(reqQ), .isrQ(isrQ), .maskQ(maskQ),
    .offsetQ(offsetQ)
  );

  irq_res_control #(.N(N)) u_ctl (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe),
    .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi),
    .candValid(candValid), .candLine(candLine), .strobe(strobe),
    .irqOut(irqOut), .irqLine(irqLine), .wakePulse(wakePulse)
  );
endmodule

// File: rtl/irq_res_checker.sv
module irq_res_checker #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rstN,
  input logic          irqOut,
  input logic          wakePulse,
  input logic          ackStrobe,
  input logic          autoEoi,
  input logic          rotateOnAutoEoi,
  input logic          candValid,
  input logic [IW-1:0] candLine,
  input logic [N-1:0]  reqQ,
  input logic [N-1:0]  isrQ,
  input logic [N-1:0]  maskQ,
  input logic [IW-1:0] offsetQ
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (reqQ == '0 && isrQ == '0 && maskQ == '0 && offsetQ == '0));

  // R11
  wake_with_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> irqOut);

  // R11
  wake_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R11
  rise_wakes_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> wakePulse);

  // R4
  winner_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    candValid |-> (reqQ[candLine] && !maskQ[candLine]));

  // R7
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && candValid && !autoEoi) |=> isrQ[$past(candLine)]);

  // R10
  auto_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && candValid && autoEoi && rotateOnAutoEoi)
      |=> (offsetQ == $past(candLine) + IW'(1)));
endmodule

bind prio_irq_resolver irq_res_checker #(.N(N)) chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .wakePulse(wakePulse),
  .ackStrobe(ackStrobe), .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi),
  .candValid(candValid), .candLine(candLine), .reqQ(reqQ), .isrQ(isrQ),
  .maskQ(maskQ), .offsetQ(offsetQ)
);

// File: tb/prio_irq_resolver_test.sv
module prio_irq_resolver_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] reqLines, maskBits, levelMode;
  logic       isMaster, fullyNested, autoEoi, rotateOnAutoEoi;
  logic       ackStrobe, eoiStrobe;
  logic [2:0] eoiLine;
  logic       irqOut, wakePulse;
  logic [2:0] irqLine;
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_resolver uut (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .maskBits(maskBits),
    .levelMode(levelMode), .isMaster(isMaster), .fullyNested(fullyNested),
    .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi),
    .ackStrobe(ackStrobe), .eoiStrobe(eoiStrobe), .eoiLine(eoiLine),
    .irqOut(irqOut), .irqLine(irqLine), .wakePulse(wakePulse)
  );

  // {req, mask, level, expIrq, expLine}
  localparam logic [27:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 1'b0, 3'd0},
    {8'h01, 8'h00, 8'h00, 1'b1, 3'd0},
    {8'h80, 8'h00, 8'h00, 1'b1, 3'd7},
    {8'h90, 8'h00, 8'h00, 1'b1, 3'd4},
    {8'h90, 8'h10, 8'h00, 1'b1, 3'd7},
    {8'hFF, 8'hFF, 8'h00, 1'b0, 3'd0},
    {8'h0C, 8'h00, 8'h0C, 1'b1, 3'd2},
    {8'h60, 8'h20, 8'h40, 1'b1, 3'd6}
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkIrq(string tag, logic expIrq, logic [2:0] expLine);
    check({tag, " irqOut"}, {7'd0, irqOut}, {7'd0, expIrq});
    if (expIrq) check({tag, " irqLine"}, {5'd0, irqLine}, {5'd0, expLine});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    reqLines = '0; maskBits = '0; levelMode = '0;
    isMaster = 1'b0; fullyNested = 1'b0; autoEoi = 1'b0; rotateOnAutoEoi = 1'b0;
    ackStrobe = 1'b0; eoiStrobe = 1'b0; eoiLine = '0;
    step(2);
    check("R1 irqOut in reset", {7'd0, irqOut}, 8'd0);
    check("R1 wakePulse in reset", {7'd0, wakePulse}, 8'd0);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic pulseAck();
    ackStrobe = 1'b1; step(1); ackStrobe = 1'b0;
  endtask

  task automatic pulseEoi(logic [2:0] ln);
    eoiStrobe = 1'b1; eoiLine = ln; step(1); eoiStrobe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // Table: resolution from a clean state, offset 0 (R4, R5)
    for (int v = 0; v < 8; v++) begin
      doReset();
      reqLines = VEC[v][27:20]; maskBits = VEC[v][19:12]; levelMode = VEC[v][11:4];
      step(2);
      checkIrq($sformatf("R5 R4 vector %0d", v), VEC[v][3], VEC[v][2:0]);
    end

    // R11 latency and wake pulse; R2, R7, R6, R8 on edge lines
    doReset();
    reqLines = 8'h08;
    step(1); check("R11 irqOut one clock late", {7'd0, irqOut}, 8'd0);
    step(1); checkIrq("R11 rise", 1'b1, 3'd3);
    check("R11 wakePulse on rise", {7'd0, wakePulse}, 8'd1);
    step(1); check("R11 wakePulse single", {7'd0, wakePulse}, 8'd0);
    reqLines = 8'h00; step(2);
    checkIrq("R2 low keeps request", 1'b1, 3'd3);
    reqLines = 8'h08; step(2);
    pulseAck(); step(1);
    checkIrq("R7 ack clears edge request", 1'b0, 3'd0);
    step(3);
    checkIrq("R2 held high no re-request", 1'b0, 3'd0);
    reqLines = 8'h00; step(1); reqLines = 8'h08; step(2);
    checkIrq("R6 equal priority waits", 1'b0, 3'd0);
    reqLines = 8'h0A; step(2);
    checkIrq("R6 higher priority nests", 1'b1, 3'd1);
    pulseAck(); step(1);
    checkIrq("R7 nested ack", 1'b0, 3'd0);
    pulseEoi(3'd1); step(1);
    checkIrq("R8 line 3 still in service", 1'b0, 3'd0);
    pulseEoi(3'd3); step(1);
    checkIrq("R8 eoi releases line 3", 1'b1, 3'd3);

    // R3 level line
    doReset();
    levelMode = 8'h20; reqLines = 8'h20; step(2);
    checkIrq("R3 level request", 1'b1, 3'd5);
    pulseAck(); step(1);
    checkIrq("R3 in service blocks", 1'b0, 3'd0);
    pulseEoi(3'd5); step(1);
    checkIrq("R3 ack keeps level request", 1'b1, 3'd5);
    reqLines = 8'h00; step(2);
    checkIrq("R3 low clears request", 1'b0, 3'd0);

    // R4 masked request stays pending
    doReset();
    maskBits = 8'h04; reqLines = 8'h04; step(2);
    checkIrq("R4 masked", 1'b0, 3'd0);
    maskBits = 8'h00; step(2);
    checkIrq("R4 unmasked later", 1'b1, 3'd2);

    // R9 special fully nested on master
    doReset();
    isMaster = 1'b1; fullyNested = 1'b1; reqLines = 8'h04; step(2);
    checkIrq("R9 cascade line", 1'b1, 3'd2);
    pulseAck(); step(1);
    reqLines = 8'h0C; step(2);
    checkIrq("R9 master ignores isr bit 2", 1'b1, 3'd3);
    isMaster = 1'b0; step(2);
    checkIrq("R9 slave role counts isr bit 2", 1'b0, 3'd0);

    // R10 auto EOI with rotation, R5 rotated scan
    doReset();
    autoEoi = 1'b1; rotateOnAutoEoi = 1'b1; levelMode = 8'hFF; reqLines = 8'h81; step(2);
    checkIrq("R5 line 0 first", 1'b1, 3'd0);
    pulseAck(); step(1);
    checkIrq("R10 rotated winner line 7", 1'b1, 3'd7);
    pulseAck(); step(1);
    checkIrq("R10 rotation wraps to line 0", 1'b1, 3'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule